// File: doc/BRIEF.md
# Indexed control register port

This block is the register front end of a network controller as seen from a host over a small I/O window of 16-bit words. The host first writes a register index into a pointer word. A later access to one of two data words then reaches the register that index names: one data word opens the control/status register space, the other opens the bus configuration register space. Reading a fourth word returns zero and resets the whole block, as a software reset of the controller.

Index 0 of the control/status space is the command and status word. Its command bits start initialisation, start operation, stop the controller and request a transmit poll. A status flag reports the end of initialisation after a fixed, parameterised delay. The other registers hold the 32-bit address of the initialisation block, a read-only identification pair, a descriptor style selector and the two fields that choose whole-packet transmit buffering. The decoded values leave the block on plain outputs for the DMA and MAC logic beside it.

Top module: `ctrl_regport`

## Requirements
- R1: After the hardware reset the command word (control index 0) reads 0x0004, the pointer reads 0, the init-block address output is 0, and `running`, `tx_poll`, `wide_desc` and `tx_whole_pkt` are low.
- R2: A write to offset 0x12 stores the low 7 bits of the data as the pointer. A read of 0x12 returns that index zero-extended to 16 bits, so writing 88 reads back 88 and writing 0xFFD8 reads back 0x0058.
- R3: An access at offset 0x10 reaches the control register named by the pointer. An access at offset 0x16 reaches the configuration register of the same index. The two spaces are independent, so a write in one never changes the other.
- R4: A read at offset 0x14 returns 0 and, at that clock edge, returns every register to its reset value: the pointer is 0, the command word reads 0x0004 and all stored fields and outputs are cleared. A write to 0x14 has no effect.
- R5: Writing a 1 to bit 0 of the command word starts initialisation. This clears STOP (bit 2) and the done flag (bit 8). Bit 0 reads 1 while initialisation is pending, and bit 8 reads 1 from the INIT_CYCLES-th clock edge after the write edge onward.
- R6: Writing a 1 to bit 1 (start) sets bit 1 and the `running` output and clears STOP.
- R7: Writing a 1 to bit 2 (stop) sets STOP, clears bit 1 and `running`, and cancels a pending initialisation so the done flag is never set. In a single write, stop takes priority over start and init.
- R8: Writing a 1 to bit 3 (transmit demand) drives `tx_poll` high for exactly the one cycle after the write edge. Bit 3 always reads 0.
- R9: Zero bits in a command-word write leave state unchanged. The done flag (bit 8) is cleared only by writing a 1 to it or by a new init.
- R10: Control index 1 is the low half and index 2 the high half of the `init_addr` output. Both are fully readable and writable.
- R11: Control indices 88 and 89 read the low and high halves of the identification word {4'h0, PART_CODE, 12'h003}, which is 0x1003 and 0x0262 with PART_CODE 0x2621. Writes to them are ignored.
- R12: Configuration index 20 keeps bits 7:0 (bits 15:8 read 0), and `wide_desc` is high when that field equals 2. Configuration index 18 keeps only bit 11 and control index 80 keeps only bits 11:10. `tx_whole_pkt` is high when bit 11 is set and both bits 11:10 are set.
- R13: Unimplemented indices in either space read 0 and ignore writes. Offsets other than 0x10, 0x12, 0x14 and 0x16 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| io_en | input | 1 | Access strobe, one access per cycle |
| io_we | input | 1 | 1 for write, 0 for read |
| io_addr | input | 5 | Byte offset inside the I/O window |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, valid in the cycle of the read |
| running | output | 1 | Controller started and not stopped |
| tx_poll | output | 1 | One-cycle transmit demand pulse |
| init_addr | output | 32 | Initialisation block address |
| wide_desc | output | 1 | 32-bit descriptor style selected |
| tx_whole_pkt | output | 1 | Whole-packet transmit buffering selected |

## Verification
Read data is combinational, so the bench drives a read after the falling edge, samples `io_rdata` 1 ns later in the same cycle, and lets any side effect (the reset offset) take hold at the next rising edge. Write effects and `tx_poll` appear after the write edge, so the bench checks them 1 ns after that edge, and `tx_poll` is checked low again one edge later. The done flag is due on the INIT_CYCLES-th edge after the init write: the bench waits INIT_CYCLES-1 edges, reads once to see it still clear, and reads again to see it set.

// File: rtl/regport_pkg.sv
package regport_pkg;

    localparam int IDX_W  = 7;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    // Window offsets: the host software depends on these.
    localparam logic [ADDR_W-1:0] OFS_CSR_DATA = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_PTR      = 5'h12;
    localparam logic [ADDR_W-1:0] OFS_RESET    = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_BCR_DATA = 5'h16;

    // Register indices that the host decodes.
    localparam logic [IDX_W-1:0] IX_CMD     = 7'd0;
    localparam logic [IDX_W-1:0] IX_IBA_LO  = 7'd1;
    localparam logic [IDX_W-1:0] IX_IBA_HI  = 7'd2;
    localparam logic [IDX_W-1:0] IX_TXTHR   = 7'd80;
    localparam logic [IDX_W-1:0] IX_ID_LO   = 7'd88;
    localparam logic [IDX_W-1:0] IX_ID_HI   = 7'd89;
    localparam logic [IDX_W-1:0] IX_BUFMODE = 7'd18;
    localparam logic [IDX_W-1:0] IX_STYLE   = 7'd20;

    // Command word bit positions.
    localparam int CB_INIT = 0;
    localparam int CB_STRT = 1;
    localparam int CB_STOP = 2;
    localparam int CB_TDMD = 3;
    localparam int CB_IDON = 8;

    localparam int THR_LSB  = 10;
    localparam int BUFM_BIT = 11;
    localparam int STYLE_W  = 8;
    localparam logic [STYLE_W-1:0] STYLE_WIDE = 8'd2;

    typedef enum logic [2:0] {
        PORT_NONE,
        PORT_CSR,
        PORT_PTR,
        PORT_RST,
        PORT_BCR
    } port_e;

    typedef struct packed {
        logic idon_clr;
        logic tdmd;
        logic stop;
        logic strt;
        logic init;
    } cmd_t;

endpackage

// File: rtl/regport_decode.sv
module regport_decode
    import regport_pkg::*;
(
    input  logic              io_en,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    output port_e             port,
    output logic              do_wr,
    output logic              soft_rst
);

    always_comb begin
        port = PORT_NONE;
        if (io_en) begin
            case (io_addr)
                OFS_CSR_DATA: port = PORT_CSR;
                OFS_PTR:      port = PORT_PTR;
                OFS_RESET:    port = PORT_RST;
                OFS_BCR_DATA: port = PORT_BCR;
                default:      port = PORT_NONE;
            endcase
        end
        do_wr    = io_en && io_we;
        soft_rst = io_en && !io_we && (port == PORT_RST);
    end

endmodule

// File: rtl/regport_cmd.sv
module regport_cmd
    import regport_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  cmd_t              cmd,
    output logic [DATA_W-1:0] cmd_rd,
    output logic              running,
    output logic              tx_poll,
    output logic              init_done
);

    localparam int CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(INIT_CYCLES - 1);

    typedef struct packed {
        logic             stop;
        logic             run;
        logic             idon;
        logic             busy;
        logic             poll;
        logic [CNT_W-1:0] cnt;
    } st_t;

    localparam st_t ST_RESET = '{stop: 1'b1, run: 1'b0, idon: 1'b0,
                                 busy: 1'b0, poll: 1'b0, cnt: '0};

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.poll = 1'b0;

        // Init countdown.
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.idon = 1'b1;
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        // Write-one-to-act commands; later lines take priority.
        if (wr_en) begin
            if (cmd.idon_clr) begin
                st_d.idon = 1'b0;
            end
            if (cmd.init) begin
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_LOAD;
                st_d.idon = 1'b0;
                st_d.stop = 1'b0;
            end
            if (cmd.strt) begin
                st_d.run  = 1'b1;
                st_d.stop = 1'b0;
            end
            if (cmd.tdmd) begin
                st_d.poll = 1'b1;
            end
            if (cmd.stop) begin
                st_d.stop = 1'b1;
                st_d.run  = 1'b0;
                st_d.busy = 1'b0;
            end
        end

        if (soft_rst) begin
            st_d = ST_RESET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cmd_rd          = '0;
        cmd_rd[CB_INIT] = st_q.busy;
        cmd_rd[CB_STRT] = st_q.run;
        cmd_rd[CB_STOP] = st_q.stop;
        cmd_rd[CB_IDON] = st_q.idon;
    end

    assign running   = st_q.run;
    assign tx_poll   = st_q.poll;
    assign init_done = st_q.idon;

endmodule

// File: rtl/regport_bank.sv
module regport_bank
    import regport_pkg::*;
#(
    parameter logic [15:0] PART_CODE = 16'h2621
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              csr_wr,
    input  logic              bcr_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] csr_rd,
    output logic [DATA_W-1:0] bcr_rd,
    output logic [31:0]       iba,
    output logic              wide_desc,
    output logic              whole_pkt
);

    localparam logic [31:0] ID_WORD = {4'h0, PART_CODE, 12'h003};

    typedef struct packed {
        logic [DATA_W-1:0]  iba_lo;
        logic [DATA_W-1:0]  iba_hi;
        logic [1:0]         thr;
        logic               bufm;
        logic [STYLE_W-1:0] style;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (csr_wr) begin
            case (idx)
                IX_IBA_LO: bk_d.iba_lo = wdata;
                IX_IBA_HI: bk_d.iba_hi = wdata;
                IX_TXTHR:  bk_d.thr    = wdata[THR_LSB+1:THR_LSB];
                default:   ;
            endcase
        end
        if (bcr_wr) begin
            case (idx)
                IX_BUFMODE: bk_d.bufm  = wdata[BUFM_BIT];
                IX_STYLE:   bk_d.style = wdata[STYLE_W-1:0];
                default:    ;
            endcase
        end
        if (soft_rst) begin
            bk_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    always_comb begin
        csr_rd = '0;
        case (idx)
            IX_IBA_LO: csr_rd = bk_q.iba_lo;
            IX_IBA_HI: csr_rd = bk_q.iba_hi;
            IX_TXTHR:  csr_rd[THR_LSB+1:THR_LSB] = bk_q.thr;
            IX_ID_LO:  csr_rd = ID_WORD[15:0];
            IX_ID_HI:  csr_rd = ID_WORD[31:16];
            default:   csr_rd = '0;
        endcase
    end

    always_comb begin
        bcr_rd = '0;
        case (idx)
            IX_BUFMODE: bcr_rd[BUFM_BIT] = bk_q.bufm;
            IX_STYLE:   bcr_rd[STYLE_W-1:0] = bk_q.style;
            default:    bcr_rd = '0;
        endcase
    end

    assign iba       = {bk_q.iba_hi, bk_q.iba_lo};
    assign wide_desc = (bk_q.style == STYLE_WIDE);
    assign whole_pkt = bk_q.bufm && (bk_q.thr == 2'b11);

endmodule

// File: rtl/ctrl_regport.sv
module ctrl_regport
    import regport_pkg::*;
#(
    parameter int          INIT_CYCLES = 16,
    parameter logic [15:0] PART_CODE   = 16'h2621
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_en,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              running,
    output logic              tx_poll,
    output logic [31:0]       init_addr,
    output logic              wide_desc,
    output logic              tx_whole_pkt
);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } top_t;

    top_t q, d;

    port_e             port;
    logic              do_wr;
    logic              soft_rst;
    logic              cmd_wr;
    logic              csr_wr;
    logic              bcr_wr;
    cmd_t              cmd;
    logic [DATA_W-1:0] cmd_rd;
    logic [DATA_W-1:0] csr_rd;
    logic [DATA_W-1:0] bcr_rd;
    logic              init_done;
    logic [IDX_W-1:0]  cur_idx;

    assign cur_idx = q.ptr;

    regport_decode u_dec (
        .io_en    (io_en),
        .io_we    (io_we),
        .io_addr  (io_addr),
        .port     (port),
        .do_wr    (do_wr),
        .soft_rst (soft_rst)
    );

    always_comb begin
        csr_wr       = do_wr && (port == PORT_CSR);
        bcr_wr       = do_wr && (port == PORT_BCR);
        cmd_wr       = csr_wr && (q.ptr == IX_CMD);
        cmd.init     = io_wdata[CB_INIT];
        cmd.strt     = io_wdata[CB_STRT];
        cmd.stop     = io_wdata[CB_STOP];
        cmd.tdmd     = io_wdata[CB_TDMD];
        cmd.idon_clr = io_wdata[CB_IDON];
    end

    regport_cmd #(
        .INIT_CYCLES (INIT_CYCLES)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_en     (cmd_wr),
        .cmd       (cmd),
        .cmd_rd    (cmd_rd),
        .running   (running),
        .tx_poll   (tx_poll),
        .init_done (init_done)
    );

    regport_bank #(
        .PART_CODE (PART_CODE)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .csr_wr    (csr_wr),
        .bcr_wr    (bcr_wr),
        .idx       (q.ptr),
        .wdata     (io_wdata),
        .csr_rd    (csr_rd),
        .bcr_rd    (bcr_rd),
        .iba       (init_addr),
        .wide_desc (wide_desc),
        .whole_pkt (tx_whole_pkt)
    );

    // Pointer register.
    always_comb begin
        d = q;
        if (do_wr && (port == PORT_PTR)) begin
            d.ptr = io_wdata[IDX_W-1:0];
        end
        if (soft_rst) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Read data return.
    always_comb begin
        case (port)
            PORT_PTR: io_rdata = {{(DATA_W-IDX_W){1'b0}}, q.ptr};
            PORT_CSR: io_rdata = (q.ptr == IX_CMD) ? cmd_rd : csr_rd;
            PORT_BCR: io_rdata = bcr_rd;
            default:  io_rdata = '0;
        endcase
    end

endmodule

// File: rtl/regport_chk.sv
module regport_chk
    import regport_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_en,
    input logic              io_we,
    input logic [ADDR_W-1:0] io_addr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              running,
    input logic              tx_poll,
    input logic [31:0]       init_addr,
    input logic [IDX_W-1:0]  cur_idx,
    input logic              idon
);

    logic        rst_rd;
    logic        ptr_wr;
    logic        ptr_rd;
    logic        wr0;
    logic        armed;
    logic [31:0] cyc;

    assign rst_rd = io_en && !io_we && (io_addr == OFS_RESET);
    assign ptr_wr = io_en && io_we && (io_addr == OFS_PTR);
    assign ptr_rd = io_en && !io_we && (io_addr == OFS_PTR);
    assign wr0    = io_en && io_we && (io_addr == OFS_CSR_DATA) && (cur_idx == IX_CMD);

    // Cycles since the last init command that was not cancelled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cyc   <= '0;
        end else if (rst_rd || (wr0 && io_wdata[CB_STOP])) begin
            armed <= 1'b0;
        end else if (wr0 && io_wdata[CB_INIT]) begin
            armed <= 1'b1;
            cyc   <= '0;
        end else if (armed && (cyc != 32'hFFFF_FFFF)) begin
            cyc <= cyc + 1;
        end
    end

    assert_ptr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ptr_wr) && ptr_rd) |-> (io_rdata == {9'b0, $past(io_wdata[IDX_W-1:0])}));

    assert_soft_reset_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rd |=> (!running && (init_addr == 32'h0) && (cur_idx == '0)));

    assert_done_after_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idon) |-> (armed && (cyc == 32'(INIT_CYCLES))));

    assert_run_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(wr0 && io_wdata[CB_STRT] && !io_wdata[CB_STOP]));

    assert_poll_follows_demand_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && io_wdata[CB_TDMD]) |=> tx_poll);

    assert_poll_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll |-> $past(wr0 && io_wdata[CB_TDMD]));

endmodule

bind ctrl_regport regport_chk #(
    .INIT_CYCLES (INIT_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_en     (io_en),
    .io_we     (io_we),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .running   (running),
    .tx_poll   (tx_poll),
    .init_addr (init_addr),
    .cur_idx   (cur_idx),
    .idon      (init_done)
);

// File: tb/test_ctrl_regport.sv
module test_ctrl_regport;

    localparam int CLK_PERIOD = 10;
    localparam int INIT_N     = 16;
    localparam logic [4:0] A_CSR = 5'h10;
    localparam logic [4:0] A_PTR = 5'h12;
    localparam logic [4:0] A_RST = 5'h14;
    localparam logic [4:0] A_BCR = 5'h16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_en = 1'b0;
    logic        io_we = 1'b0;
    logic [4:0]  io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        running;
    logic        tx_poll;
    logic [31:0] init_addr;
    logic        wide_desc;
    logic        tx_whole_pkt;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model of the stored fields.
    logic [15:0] m_lo, m_hi;
    logic [1:0]  m_thr;
    logic        m_bufm;
    logic [7:0]  m_style;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctrl_regport #(.INIT_CYCLES(INIT_N), .PART_CODE(16'h2621)) i_ctrl_regport (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_en        (io_en),
        .io_we        (io_we),
        .io_addr      (io_addr),
        .io_wdata     (io_wdata),
        .io_rdata     (io_rdata),
        .running      (running),
        .tx_poll      (tx_poll),
        .init_addr    (init_addr),
        .wide_desc    (wide_desc),
        .tx_whole_pkt (tx_whole_pkt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        io_en = 1'b1; io_we = 1'b1; io_addr = a; io_wdata = v;
        @(posedge clk);
        #1;
        io_en = 1'b0; io_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        io_en = 1'b1; io_we = 1'b0; io_addr = a;
        #1;
        v = io_rdata;
        @(posedge clk);
        #1;
        io_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, {16'h0, v}, {16'h0, exp});
    endtask

    function automatic logic [15:0] exp_csr(input logic [6:0] ix);
        case (ix)
            7'd1:    return m_lo;
            7'd2:    return m_hi;
            7'd80:   return {4'h0, m_thr, 10'h0};
            7'd88:   return 16'h1003;
            7'd89:   return 16'h0262;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_bcr(input logic [6:0] ix);
        case (ix)
            7'd18:   return {4'h0, m_bufm, 11'h0};
            7'd20:   return {8'h0, m_style};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [6:0] pick_idx(input int k);
        case (k)
            0: return 7'd1;
            1: return 7'd2;
            2: return 7'd80;
            3: return 7'd88;
            4: return 7'd89;
            5: return 7'd18;
            6: return 7'd20;
            7: return 7'd5;
            default: return 7'd127;
        endcase
    endfunction

    task automatic model_clear();
        m_lo = '0; m_hi = '0; m_thr = '0; m_bufm = 1'b0; m_style = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [6:0]  cur;
        void'($urandom(32'd5417));
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1", A_CSR, 16'h0004);
        rd_chk("R1", A_PTR, 16'h0000);
        chk("R1", {running, tx_poll, wide_desc, tx_whole_pkt}, 4'b0000);
        chk("R1", init_addr, 32'h0);

        // R2: pointer readback and width
        wr(A_PTR, 16'd88);
        rd_chk("R2", A_PTR, 16'd88);
        wr(A_PTR, 16'hFFD8);
        rd_chk("R2", A_PTR, 16'h0058);

        // R11: identification pair, read only
        wr(A_PTR, 16'd88);
        rd_chk("R11", A_CSR, 16'h1003);
        wr(A_CSR, 16'hBEEF);
        rd_chk("R11", A_CSR, 16'h1003);
        wr(A_PTR, 16'd89);
        rd_chk("R11", A_CSR, 16'h0262);

        // R10: init block address halves
        wr(A_PTR, 16'd1);
        wr(A_CSR, 16'h5678);
        wr(A_PTR, 16'd2);
        wr(A_CSR, 16'h1234);
        chk("R10", init_addr, 32'h1234_5678);
        rd_chk("R10", A_CSR, 16'h1234);

        // R3, R12: same index in both spaces
        wr(A_PTR, 16'd20);
        wr(A_BCR, 16'hFF02);
        chk("R12", wide_desc, 1'b1);
        rd_chk("R12", A_BCR, 16'h0002);
        wr(A_CSR, 16'hAAAA);
        rd_chk("R3", A_CSR, 16'h0000);
        rd_chk("R3", A_BCR, 16'h0002);
        wr(A_PTR, 16'd18);
        wr(A_BCR, 16'hFFFF);
        rd_chk("R12", A_BCR, 16'h0800);
        chk("R12", tx_whole_pkt, 1'b0);
        wr(A_PTR, 16'd80);
        wr(A_CSR, 16'hFFFF);
        rd_chk("R12", A_CSR, 16'h0C00);
        chk("R12", tx_whole_pkt, 1'b1);

        // R13: unimplemented index and offsets
        wr(A_PTR, 16'd7);
        wr(A_CSR, 16'hFFFF);
        rd_chk("R13", A_CSR, 16'h0000);
        wr(5'h18, 16'hFFFF);
        rd_chk("R13", 5'h18, 16'h0000);
        rd_chk("R13", A_PTR, 16'd7);

        // R5: init handshake timing
        wr(A_PTR, 16'd0);
        wr(A_CSR, 16'h0001);
        repeat (INIT_N - 1) @(posedge clk);
        rd_chk("R5", A_CSR, 16'h0001);
        rd_chk("R5", A_CSR, 16'h0100);

        // R6: start
        wr(A_CSR, 16'h0002);
        rd_chk("R6", A_CSR, 16'h0102);
        chk("R6", running, 1'b1);

        // R9: zero bits and done-flag clear
        wr(A_CSR, 16'h0000);
        rd_chk("R9", A_CSR, 16'h0102);
        wr(A_CSR, 16'h0100);
        rd_chk("R9", A_CSR, 16'h0002);

        // R8: transmit demand pulse
        wr(A_CSR, 16'h0008);
        chk("R8", tx_poll, 1'b1);
        @(posedge clk);
        #1 chk("R8", tx_poll, 1'b0);
        rd_chk("R8", A_CSR, 16'h0002);

        // R7: stop, priority, and init cancel
        wr(A_CSR, 16'h0004);
        rd_chk("R7", A_CSR, 16'h0004);
        chk("R7", running, 1'b0);
        wr(A_CSR, 16'h0006);
        rd_chk("R7", A_CSR, 16'h0004);
        wr(A_CSR, 16'h0001);
        wr(A_CSR, 16'h0004);
        repeat (INIT_N + 2) @(posedge clk);
        rd_chk("R7", A_CSR, 16'h0004);

        // R4: write to reset offset is ignored; read resets
        wr(A_CSR, 16'h0002);
        wr(A_PTR, 16'd1);
        wr(A_RST, 16'hFFFF);
        rd_chk("R4", A_PTR, 16'd1);
        chk("R4", running, 1'b1);
        rd_chk("R4", A_RST, 16'h0000);
        rd_chk("R4", A_PTR, 16'h0000);
        rd_chk("R4", A_CSR, 16'h0004);
        chk("R4", {running, wide_desc, tx_whole_pkt}, 3'b000);
        chk("R4", init_addr, 32'h0);
        model_clear();

        // Random traffic over the stored and fixed registers (R3, R10-R13).
        wr(A_PTR, 16'd1);
        cur = 7'd1;
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [15:0] dat;
            op  = int'($urandom % 5);
            dat = 16'($urandom);
            case (op)
                0: begin
                    cur = pick_idx(int'($urandom % 9));
                    wr(A_PTR, {dat[15:7], cur});
                    rd_chk("R2", A_PTR, {9'h0, cur});
                end
                1: begin
                    wr(A_CSR, dat);
                    case (cur)
                        7'd1:  m_lo  = dat;
                        7'd2:  m_hi  = dat;
                        7'd80: m_thr = dat[11:10];
                        default: ;
                    endcase
                end
                2: begin
                    wr(A_BCR, dat);
                    case (cur)
                        7'd18: m_bufm  = dat[11];
                        7'd20: m_style = dat[7:0];
                        default: ;
                    endcase
                end
                3: rd_chk("R3", A_CSR, exp_csr(cur));
                default: rd_chk("R3", A_BCR, exp_bcr(cur));
            endcase
            chk("R10", init_addr, {m_hi, m_lo});
            chk("R12", {wide_desc, tx_whole_pkt},
                {(m_style == 8'd2), (m_bufm && (m_thr == 2'b11))});
        end
        rd_chk("R13", A_CSR, exp_csr(cur));
        chk("R6", running, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule